// File: doc/BRIEF.md
# Host Command Word Decoder

This block sits behind a host control bus and reads a stream of 16-bit command words. It decodes the leading 4-bit operation code of each command. It then collects any count and address words that follow and turns the command into accesses on internal storage. The storage is two 20-bit data RAM banks and a 20-bit register file of 2^REG_AW entries. Register accesses move one value. Memory commands move a block of values with an address that advances after each value, either as full 20-bit values or in a reduced 16-bit form. Read results leave through a 16-bit output word port with a valid/ready handshake.

Operation codes 0 to 3 form a run request. The low 14 bits of that word are a start address. A zero start address is reported as a freeze request instead of a start. Codes 4 to 9 are consumed without touching storage and latch a sticky unsupported-command indication.

Because a 20-bit value does not fit a 16-bit word, full-mode values travel as two words: first the high word, then the low word. While a read block is draining, the input stays stalled, so the host cannot overlap commands.

Top module: `hcmd_decoder`

## Requirements
- R1: A synchronous reset leaves in_ready high, out_valid low, run_start and run_freeze low and cmd_unsupported low.
- R2: A word with operation code 0..3 (bits 15:12) is a run request: one clock after it is accepted, run_start pulses for one cycle with run_addr equal to bits 13:0 of the word, when those bits are nonzero.
- R3: A run request whose bits 13:0 are zero pulses run_freeze instead of run_start, with run_addr zero; the two pulses never occur together.
- R4: Code 0xB writes a register: the index is in bits 7:0 of the command word, the next word carries the value's top 4 bits in its bits 3:0 and the word after carries the low 16 bits; code 0xA with the index in bits 7:0 returns that register as a high word {12'b0, bits 19:16} then a low word of bits 15:0.
- R5: Codes 0xC and 0xD read bank 0 and bank 1, codes 0xE and 0xF write bank 0 and bank 1; bits 11:8 of the command word are a mode nibble (zero = full mode, nonzero = short mode), the second word is the value count and the third word holds the start address in its low ADDR_W bits.
- R6: In full mode each value occupies two words, high word {12'b0, bits 19:16} first, then bits 15:0; the address increments per value and wraps from the last bank entry to entry 0.
- R7: In short mode each value is one word: a write stores the word with bits 19:16 cleared, and a read returns bits 15:0 of the stored value.
- R8: A memory command with count 0 moves no data words, produces no output and leaves the block ready for a new command after the address word.
- R9: A write to one bank changes neither the other bank nor the register file.
- R10: Codes 4..9 are consumed as single words, access no storage and set cmd_unsupported, which stays set until reset.
- R11: While a read result is pending on the output, in_ready is low; an output word not taken by out_ready stays valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command word present |
| in_ready | output | 1 | Block accepts a command word this cycle |
| in_word | input | 16 | Command, count, address or data word |
| out_valid | output | 1 | Read result word present |
| out_ready | input | 1 | Host takes the result word |
| out_word | output | 16 | Read result word |
| run_start | output | 1 | One-cycle start-execution pulse |
| run_freeze | output | 1 | One-cycle freeze pulse (start address zero) |
| run_addr | output | 14 | Start address of the latest run request |
| cmd_unsupported | output | 1 | Sticky flag for consumed codes without storage action |

## Verification
A wrong internal state shows at the ports within a few cycles. A miscounted block leaves the input stalled or returns too few or too many result words. A wrong bank, mode or address increment shows up as a mismatched value on the next read-back of that range. The bench keeps a behavioural copy of all three storage spaces and a queue of expected result words and run events, and compares each handshake and each pulse in the cycle it happens. That places a fault at the first word it corrupts, and random gaps in out_ready exercise the hold behaviour.

// File: rtl/hcmd_pkg.sv
package hcmd_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CNT, S_ADR, S_WHI, S_WLO, S_RISS, S_RWAIT, S_RHI, S_RLO
  } hcmd_state_t;

  localparam logic [3:0] OP_REG_RD = 4'hA;
  localparam logic [3:0] OP_REG_WR = 4'hB;
  localparam logic [1:0] STORE_REG = 2'd2;
endpackage

// File: rtl/hcmd_ram.sv
module hcmd_ram #(
  parameter int DW = 20,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/hcmd_outbuf.sv
module hcmd_outbuf #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_word  <= load_word;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/hcmd_decoder.sv
module hcmd_decoder
  import hcmd_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DATA_W = 20,
  parameter int ADDR_W = 8,
  parameter int REG_AW = 8,
  parameter int CNT_W  = 16,
  parameter int RUN_W  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              run_start,
  output logic              run_freeze,
  output logic [RUN_W-1:0]  run_addr,
  output logic              cmd_unsupported
);
  localparam int HI_W   = DATA_W - WORD_W;
  localparam int AW_MAX = (ADDR_W > REG_AW) ? ADDR_W : REG_AW;
  localparam logic [AW_MAX-1:0] AMASK = AW_MAX'((1 << ADDR_W) - 1);
  localparam int NSTORE = 3;

  hcmd_state_t       state;
  logic [CNT_W-1:0]  cnt_q;
  logic [AW_MAX-1:0] addr_q;
  logic [1:0]        bank_q;
  logic              short_q;
  logic              is_wr_q;
  logic [HI_W-1:0]   hi_q;
  logic [WORD_W-1:0] lo_q;

  logic [3:0]        op;
  logic              in_fire;
  logic              out_fire;
  logic              wr_stb;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata [NSTORE];
  logic [DATA_W-1:0] rd_sel;
  logic              load;
  logic [WORD_W-1:0] load_word;
  logic [AW_MAX-1:0] addr_nxt;

  assign op       = in_word[WORD_W-1:WORD_W-4];
  assign in_ready = (state == S_IDLE) || (state == S_CNT) || (state == S_ADR) ||
                    (state == S_WHI) || (state == S_WLO);
  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;
  assign wr_stb   = in_fire && (state == S_WLO);
  assign wdata    = short_q ? {{HI_W{1'b0}}, in_word} : {hi_q, in_word};
  assign addr_nxt = (addr_q + 1'b1) & AMASK;

  always_comb begin
    case (bank_q)
      2'd0:    rd_sel = rdata[0];
      2'd1:    rd_sel = rdata[1];
      default: rd_sel = rdata[2];
    endcase
  end

  always_comb begin
    load      = 1'b0;
    load_word = lo_q;
    if (state == S_RWAIT) begin
      load      = 1'b1;
      load_word = short_q ? rd_sel[WORD_W-1:0]
                          : {{(WORD_W-HI_W){1'b0}}, rd_sel[DATA_W-1:WORD_W]};
    end else if (state == S_RHI && out_fire) begin
      load = 1'b1;
    end
  end

  for (genvar g = 0; g < NSTORE; g++) begin : g_store
    localparam int AWG = (g == 2) ? REG_AW : ADDR_W;
    hcmd_ram #(.DW(DATA_W), .AW(AWG)) u_ram (
      .clk   (clk),
      .we    (wr_stb && (bank_q == 2'(g))),
      .re    ((state == S_RISS) && (bank_q == 2'(g))),
      .addr  (addr_q[AWG-1:0]),
      .wdata (wdata),
      .rdata (rdata[g])
    );
  end

  hcmd_outbuf #(.WORD_W(WORD_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_word (load_word),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_word  (out_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= S_IDLE;
      cnt_q           <= '0;
      addr_q          <= '0;
      bank_q          <= '0;
      short_q         <= 1'b0;
      is_wr_q         <= 1'b0;
      hi_q            <= '0;
      lo_q            <= '0;
      run_start       <= 1'b0;
      run_freeze      <= 1'b0;
      run_addr        <= '0;
      cmd_unsupported <= 1'b0;
    end else begin
      run_start  <= 1'b0;
      run_freeze <= 1'b0;
      case (state)
        S_IDLE: if (in_fire) begin
          if (op[3:2] == 2'b00) begin
            run_addr <= in_word[RUN_W-1:0];
            if (in_word[RUN_W-1:0] == '0) run_freeze <= 1'b1;
            else                          run_start  <= 1'b1;
          end else if (op == OP_REG_RD || op == OP_REG_WR) begin
            bank_q  <= STORE_REG;
            addr_q  <= AW_MAX'(in_word[REG_AW-1:0]);
            cnt_q   <= CNT_W'(1);
            short_q <= 1'b0;
            state   <= (op == OP_REG_RD) ? S_RISS : S_WHI;
          end else if (op[3:2] == 2'b11) begin
            bank_q  <= {1'b0, op[0]};
            is_wr_q <= op[1];
            short_q <= |in_word[11:8];
            state   <= S_CNT;
          end else begin
            cmd_unsupported <= 1'b1;
          end
        end
        S_CNT: if (in_fire) begin
          cnt_q <= in_word[CNT_W-1:0];
          state <= S_ADR;
        end
        S_ADR: if (in_fire) begin
          addr_q <= AW_MAX'(in_word[ADDR_W-1:0]);
          if (cnt_q == '0)  state <= S_IDLE;
          else if (is_wr_q) state <= short_q ? S_WLO : S_WHI;
          else              state <= S_RISS;
        end
        S_WHI: if (in_fire) begin
          hi_q  <= in_word[HI_W-1:0];
          state <= S_WLO;
        end
        S_WLO: if (in_fire) begin
          addr_q <= addr_nxt;
          cnt_q  <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) state <= S_IDLE;
          else                    state <= short_q ? S_WLO : S_WHI;
        end
        S_RISS:  state <= S_RWAIT;
        S_RWAIT: begin
          lo_q  <= rd_sel[WORD_W-1:0];
          state <= short_q ? S_RLO : S_RHI;
        end
        S_RHI: if (out_fire) state <= S_RLO;
        S_RLO: if (out_fire) begin
          addr_q <= addr_nxt;
          cnt_q  <= cnt_q - 1'b1;
          state  <= (cnt_q == CNT_W'(1)) ? S_IDLE : S_RISS;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hcmd_decoder_chk.sv
module hcmd_decoder_chk #(
  parameter int WORD_W = 16,
  parameter int RUN_W  = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word,
  input logic              run_start,
  input logic              run_freeze,
  input logic [RUN_W-1:0]  run_addr,
  input logic              cmd_unsupported
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!out_valid && !run_start && !run_freeze && !cmd_unsupported)); // R1
  AST_START_NONZERO: assert property (@(posedge clk) disable iff (rst)
    run_start |-> (run_addr != '0)); // R2
  AST_RUN_FROM_WORD: assert property (@(posedge clk) disable iff (rst)
    (run_start || run_freeze) |-> $past(in_valid && in_ready)); // R2
  AST_FREEZE_ZERO: assert property (@(posedge clk) disable iff (rst)
    run_freeze |-> (run_addr == '0)); // R3
  AST_RUN_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(run_start && run_freeze)); // R3
  AST_UNSUP_STICKY: assert property (@(posedge clk) disable iff (rst)
    cmd_unsupported |=> cmd_unsupported); // R10
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word))); // R11
  AST_INPUT_STALLED: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready); // R11
endmodule

bind hcmd_decoder hcmd_decoder_chk #(.WORD_W(WORD_W), .RUN_W(RUN_W)) u_chk (.*);

// File: tb/hcmd_decoder_test.sv
module hcmd_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_word;
  logic        run_start, run_freeze, cmd_unsupported;
  logic [13:0] run_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  hcmd_decoder uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .run_start(run_start), .run_freeze(run_freeze), .run_addr(run_addr),
    .cmd_unsupported(cmd_unsupported)
  );

  int          checks = 0;
  int          fails  = 0;
  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic [14:0] run_q [$];
  logic [19:0] model [3][256];
  bit          stall = 1'b0;
  logic [7:0]  lfsr  = 8'hA5;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  // reference comparison on every falling edge
  always @(negedge clk) begin
    logic [15:0] e;
    string       t;
    logic [14:0] r;
    if (!rst) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = !stall && (lfsr[0] || lfsr[1]);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R11", "unexpected output word", out_word, 0);
        else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_word == e, t, "output word", out_word, e);
        end
      end
      if (run_start || run_freeze) begin
        if (run_q.size() == 0) check(1'b0, "R2", "unexpected run pulse", {run_freeze, run_addr}, 0);
        else begin
          r = run_q.pop_front();
          check({run_freeze, run_addr} == r, r[14] ? "R3" : "R2", "run pulse {freeze,addr}",
                {run_freeze, run_addr}, r);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    report();
  end

  function automatic logic [19:0] pat(input int s, input int i);
    return 20'((s * 32'h9E37 + i * 32'h1F3) ^ (i << 9) ^ (s << 14));
  endfunction

  task automatic send(input logic [15:0] w);
    in_valid = 1'b1;
    in_word  = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic push(input logic [15:0] w, input string tag);
    exp_q.push_back(w);
    tag_q.push_back(tag);
  endtask

  task automatic reg_write(input int a, input logic [19:0] v);
    send(16'hB000 | 16'(a));
    send({12'h0, v[19:16]});
    send(v[15:0]);
    model[2][a] = v;
  endtask

  task automatic reg_read(input int a, input string tag);
    push({12'h0, model[2][a][19:16]}, tag);
    push(model[2][a][15:0], tag);
    send(16'hA000 | 16'(a));
  endtask

  task automatic mem_write(input int bank, input logic [3:0] aux, input int addr,
                           input int n, input int seed);
    logic [19:0] v;
    send({(bank != 0) ? 4'hF : 4'hE, aux, 8'h00});
    send(16'(n));
    send(16'(addr));
    for (int i = 0; i < n; i++) begin
      v = pat(seed, i);
      if (aux != 0) begin
        send(v[15:0]);
        model[bank][(addr + i) % 256] = {4'h0, v[15:0]};
      end else begin
        send({12'h0, v[19:16]});
        send(v[15:0]);
        model[bank][(addr + i) % 256] = v;
      end
    end
  endtask

  task automatic mem_read(input int bank, input logic [3:0] aux, input int addr,
                          input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      if (aux == 0) push({12'h0, model[bank][(addr + i) % 256][19:16]}, tag);
      push(model[bank][(addr + i) % 256][15:0], tag);
    end
    send({(bank != 0) ? 4'hD : 4'hC, aux, 8'h00});
    send(16'(n));
    send(16'(addr));
  endtask

  task automatic drain();
    for (int i = 0; i < 5000 && exp_q.size() != 0; i++) @(negedge clk);
    while (!in_ready) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
    check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    check(!run_start && !run_freeze, "R1", "run pulses in reset", {run_start, run_freeze}, 0);
    check(cmd_unsupported == 1'b0, "R1", "unsupported flag in reset", cmd_unsupported, 0);
    rst = 1'b0;
    @(negedge clk);

    // R4: fill and read back register file
    for (int a = 0; a < 256; a++) reg_write(a, pat(1, a));
    reg_read(0, "R4");
    reg_read(255, "R4");
    reg_read(8'h5A, "R4");

    // R5, R6: full-mode block fill of both banks, read-back with wrap
    mem_write(0, 4'h0, 0, 256, 2);
    mem_write(1, 4'h0, 0, 256, 3);
    mem_read(0, 4'h0, 0, 256, "R6");
    mem_read(1, 4'h0, 8'hF8, 16, "R6");

    // R7: short mode write and read, full read shows cleared upper bits
    mem_write(1, 4'h1, 8'h10, 5, 4);
    mem_read(1, 4'hF, 8'h0E, 8, "R7");
    mem_read(1, 4'h0, 8'h10, 5, "R7");
    mem_write(0, 4'h8, 8'hFE, 4, 5);
    mem_read(0, 4'h0, 8'hFC, 8, "R7");

    // R9: other bank and registers untouched by those writes
    mem_read(0, 4'h0, 8'h10, 5, "R9");
    reg_read(8'h10, "R9");
    mem_read(1, 4'h0, 8'hFE, 4, "R9");

    // R8: zero-count commands, then a normal command still works
    mem_write(0, 4'h0, 8'h40, 0, 6);
    mem_read(1, 4'h0, 8'h40, 0, "R8");
    mem_write(1, 4'h2, 8'h41, 0, 6);
    reg_read(3, "R8");
    drain();
    check(exp_q.size() == 0, "R8", "pending words after zero count", exp_q.size(), 0);

    // R10: unsupported codes are consumed, flag sticky, no storage access
    check(cmd_unsupported == 1'b0, "R10", "flag before unsupported code", cmd_unsupported, 0);
    send(16'h5123);
    check(cmd_unsupported == 1'b1, "R10", "flag after code 5", cmd_unsupported, 1);
    send(16'h4000); send(16'h6E00); send(16'h7F10); send(16'h8C00); send(16'h9D01);
    mem_read(0, 4'h0, 0, 4, "R10");
    mem_read(1, 4'h0, 0, 4, "R10");
    reg_read(0, "R10");
    reg_read(1, "R10");

    // R2, R3: run requests
    run_q.push_back({1'b0, 14'h2ABC}); send(16'h2ABC);
    run_q.push_back({1'b1, 14'h0000}); send(16'h0000);
    run_q.push_back({1'b0, 14'h3FFF}); send(16'h3FFF);
    run_q.push_back({1'b0, 14'h0001}); send(16'h0001);
    @(negedge clk);
    check(run_q.size() == 0, "R2", "missing run pulses", run_q.size(), 0);
    check(cmd_unsupported == 1'b1, "R10", "flag still set", cmd_unsupported, 1);

    // R11: output held and input stalled while result not taken
    drain();
    stall = 1'b1;
    @(negedge clk);
    reg_read(8'h22, "R11");
    repeat (6) @(negedge clk);
    check(out_valid == 1'b1, "R11", "out_valid while stalled", out_valid, 1);
    check(in_ready == 1'b0, "R11", "in_ready while result pending", in_ready, 0);
    check(out_word == {12'h0, model[2][8'h22][19:16]}, "R11", "held word",
          out_word, {12'h0, model[2][8'h22][19:16]});
    repeat (3) @(negedge clk);
    check(out_word == {12'h0, model[2][8'h22][19:16]}, "R11", "word still held",
          out_word, {12'h0, model[2][8'h22][19:16]});
    stall = 1'b0;
    drain();
    check(exp_q.size() == 0, "R11", "undelivered words", exp_q.size(), 0);
    report();
  end
endmodule